// File: doc/BRIEF.md
# Interrupt Status and Masking Unit

This block collects event strobes from a removable-card host controller (command and data engine, card-detect logic, timers) and turns them into sticky status bits plus one level interrupt line. Two separate masks shape its behaviour. The latch mask decides which incoming events are recorded at all. The pin mask decides which recorded bits may raise the interrupt output.

Software uses a small word-wide register port. It reads the status word, clears status bits by writing ones back to them, and programs the two masks at their own addresses. A summary error bit in the status word shows whether any of the four error causes is currently recorded. Both masks come out of reset with every event enabled except the two FIFO-ready bits. A driver turns those on only for programmed-I/O transfers.

Top module: `isr_unit`

## Requirements
- R1: After reset the status word reads 0, both masks read 0x000F801F and `irq_o` is 0.
- R2: Event bits sit at these positions: 0 end of command, 1 end of data transfer, 2 DMA boundary, 3 card in, 4 card out, 6 read FIFO ready, 7 write FIFO ready, 16 handshake timeout, 17 timer timeout, 18 CRC error, 19 command error. A one on `evt_i[b]` sets status bit b at the next clock edge when latch-mask bit b is 1, and the bit then stays set.
- R3: An event whose latch-mask bit is 0 is never recorded, and its status bit stays 0.
- R4: Writing a word to address 0 clears every status bit that is 1 in the written word and leaves the other bits unchanged.
- R5: When an enabled event and a clear of the same bit arrive in the same cycle, the bit is left set.
- R6: Status bit 15 reads 1 exactly when at least one of bits 16 to 19 is set. It is not cleared directly, and `evt_i[15]` has no effect.
- R7: `irq_o` is a register. It is 1 in the cycle after a cycle in which some status bit and the same pin-mask bit are both 1, and 0 otherwise.
- R8: With both masks at zero, no event raises `irq_o`.
- R9: The latch mask (address 1) and the pin mask (address 2) are written independently. Only implemented bits (0x000F80DF) are stored, and the other bits read 0. Address 3 reads 0.
- R10: Clearing a latch-mask bit leaves an already recorded status bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 32 | Event strobes, one per status bit position |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 status, 1 latch mask, 2 pin mask |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the selected register (combinational) |
| irq_o | output | 1 | Level interrupt output |

## Verification
A behavioural model steps along with the design and compares the read data and the interrupt line on every clock. Events are first driven under the reset masks, to show latching apart from dropping. Narrow latch masks and mask changes then separate the drop rule from the rule that recorded bits stay (R3, R10). Clears that coincide with events on the same bits test event priority. Error bursts followed by attempts to clear bit 15 directly test the summary bit. Several pin-mask values, including an all-zero pair of masks, test the gating and the one-cycle delay of the interrupt. A long random mix covers the interaction of all of these.

// File: rtl/isr_unit_pkg.sv
package isr_unit_pkg;
  localparam int W = 32;

  localparam int B_CMD_END  = 0;
  localparam int B_XFER_END = 1;
  localparam int B_DMA_BND  = 2;
  localparam int B_CARD_IN  = 3;
  localparam int B_CARD_OUT = 4;
  localparam int B_RD_RDY   = 6;
  localparam int B_WR_RDY   = 7;
  localparam int B_ERR_ANY  = 15;
  localparam int B_HS_TMO   = 16;
  localparam int B_TMR_TMO  = 17;
  localparam int B_CRC      = 18;
  localparam int B_CMD_ERR  = 19;

  localparam logic [W-1:0] ONE = W'(1);

  localparam logic [W-1:0] ERR_CAUSES =
    (ONE << B_HS_TMO) | (ONE << B_TMR_TMO) | (ONE << B_CRC) | (ONE << B_CMD_ERR);
  localparam logic [W-1:0] FIFO_BITS = (ONE << B_RD_RDY) | (ONE << B_WR_RDY);
  localparam logic [W-1:0] EVT_MASK =
    ERR_CAUSES | FIFO_BITS | (ONE << B_CMD_END) | (ONE << B_XFER_END) |
    (ONE << B_DMA_BND) | (ONE << B_CARD_IN) | (ONE << B_CARD_OUT);
  localparam logic [W-1:0] IMPL_MASK = EVT_MASK | (ONE << B_ERR_ANY);
  localparam logic [W-1:0] EN_RESET  = IMPL_MASK & ~FIFO_BITS;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_LATCH  = 2'd1,
    SEL_PIN    = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/isr_mask_reg.sv
module isr_mask_reg #(
  parameter int unsigned  DW       = 32,
  parameter logic [DW-1:0] RST_VAL = '0,
  parameter logic [DW-1:0] KEEP    = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] mask_d, mask_q;

  always_comb begin
    mask_d = wdata_i & KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= RST_VAL;
    end else if (we_i) begin
      mask_q <= mask_d;
    end
  end

  assign q_o = mask_q;
endmodule

// File: rtl/isr_status_bank.sv
module isr_status_bank
  import isr_unit_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] view_o
);
  logic [W-1:0] hit;
  logic [W-1:0] st_d, st_q;

  always_comb begin
    hit  = evt_i & en_i & EVT_MASK;
    st_d = ((st_q & ~clr_i) | hit) & EVT_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else begin
      st_q <= st_d;
    end
  end

  always_comb begin
    view_o            = st_q;
    view_o[B_ERR_ANY] = |(st_q & ERR_CAUSES);
  end

  // R3
  dropped_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_q & ~($past(st_q) | $past(evt_i & en_i))) == '0));

  // R4
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(clr_i & ~(evt_i & en_i)) & st_q) == '0));

  // R5
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(clr_i & evt_i & en_i & EVT_MASK) & ~st_q) == '0));
endmodule

// File: rtl/isr_irq_gen.sv
module isr_irq_gen #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] view_i,
  input  logic [DW-1:0] en_i,
  output logic          irq_o
);
  logic req_d, irq_q;

  always_comb begin
    req_d = |(view_i & en_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= req_d;
    end
  end

  assign irq_o = irq_q;

  // R8
  quiet_when_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i == '0) |=> !irq_o);
endmodule

// File: rtl/isr_unit.sv
module isr_unit
  import isr_unit_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         reg_we_i,
  input  logic [1:0]   reg_addr_i,
  input  logic [W-1:0] reg_wdata_i,
  output logic [W-1:0] reg_rdata_o,
  output logic         irq_o
);
  reg_sel_e     sel;
  logic         latch_we, pin_we;
  logic [W-1:0] clr_word;
  logic [W-1:0] latch_q, pin_q, status_view;

  always_comb begin
    sel      = reg_sel_e'(reg_addr_i);
    latch_we = reg_we_i && (sel == SEL_LATCH);
    pin_we   = reg_we_i && (sel == SEL_PIN);
    clr_word = (reg_we_i && (sel == SEL_STATUS)) ? reg_wdata_i : '0;
  end

  isr_mask_reg #(.DW(W), .RST_VAL(EN_RESET), .KEEP(IMPL_MASK)) u_latch_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (latch_we),
    .wdata_i(reg_wdata_i),
    .q_o    (latch_q)
  );

  isr_mask_reg #(.DW(W), .RST_VAL(EN_RESET), .KEEP(IMPL_MASK)) u_pin_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (pin_we),
    .wdata_i(reg_wdata_i),
    .q_o    (pin_q)
  );

  isr_status_bank u_status (
    .clk   (clk),
    .rst_n (rst_n),
    .evt_i (evt_i),
    .en_i  (latch_q),
    .clr_i (clr_word),
    .view_o(status_view)
  );

  isr_irq_gen #(.DW(W)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .view_i(status_view),
    .en_i  (pin_q),
    .irq_o (irq_o)
  );

  always_comb begin
    case (sel)
      SEL_STATUS: reg_rdata_o = status_view;
      SEL_LATCH:  reg_rdata_o = latch_q;
      SEL_PIN:    reg_rdata_o = pin_q;
      default:    reg_rdata_o = '0;
    endcase
  end

  // R6
  err_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_STATUS) |-> (reg_rdata_o[B_ERR_ANY] == (reg_rdata_o[19:16] != 4'd0)));
endmodule

// File: tb/isr_unit_tb.sv
module isr_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk, rst_n;
  logic [31:0] evt, wdata, rdata;
  logic        we, irq;
  logic [1:0]  addr;

  int total, bad;

  // behavioural reference state
  logic [31:0] m_st, m_latch, m_pin;
  logic        m_irq;
  int          evt_pos[$] = '{0, 1, 2, 3, 4, 6, 7, 16, 17, 18, 19};
  int          err_pos[$] = '{16, 17, 18, 19};

  isr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] impl_bits();
    logic [31:0] m = 32'h0;
    foreach (evt_pos[k]) m[evt_pos[k]] = 1'b1;
    m[15] = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] model_view();
    logic [31:0] v = m_st;
    v[15] = 1'b0;
    foreach (err_pos[k]) if (m_st[err_pos[k]]) v[15] = 1'b1;
    return v;
  endfunction

  function automatic logic [31:0] model_read(logic [1:0] a);
    case (a)
      2'd0: return model_view();
      2'd1: return m_latch;
      2'd2: return m_pin;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string tag);
    logic [31:0] exp_rd = model_read(addr);
    total++;
    if (rdata !== exp_rd) begin
      bad++;
      $display("FAIL %s rdata addr=%0d actual=%h expected=%h", tag, addr, rdata, exp_rd);
    end
    total++;
    if (irq !== m_irq) begin
      bad++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, m_irq);
    end
  endtask

  // one clock: drive at negedge, advance model after posedge, compare at next negedge
  task automatic step(input logic w, input logic [1:0] a, input logic [31:0] d,
                      input logic [31:0] e, input string tag);
    logic [31:0] n_st, n_latch, n_pin;
    logic        n_irq;
    we = w; addr = a; wdata = d; evt = e;
    @(posedge clk);
    #1;
    n_st = m_st;
    if (w && a == 2'd0) begin
      for (int b = 0; b < 32; b++) if (d[b]) n_st[b] = 1'b0;
    end
    foreach (evt_pos[k]) if (e[evt_pos[k]] && m_latch[evt_pos[k]]) n_st[evt_pos[k]] = 1'b1;
    n_latch = (w && a == 2'd1) ? (d & impl_bits()) : m_latch;
    n_pin   = (w && a == 2'd2) ? (d & impl_bits()) : m_pin;
    n_irq   = |(model_view() & m_pin);
    m_st = n_st; m_latch = n_latch; m_pin = n_pin; m_irq = n_irq;
    @(negedge clk);
    check(tag);
  endtask

  task automatic idle_read(input logic [1:0] a, input string tag);
    step(1'b0, a, 32'h0, 32'h0, tag);
  endtask

  initial begin : watchdog
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    total = 0; bad = 0;
    we = 1'b0; addr = 2'd0; wdata = 32'h0; evt = 32'h0;
    rst_n = 1'b0;
    m_st = 32'h0; m_latch = 32'h000F801F; m_pin = 32'h000F801F; m_irq = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values on every register
    for (int a = 0; a < 4; a++) begin
      addr = 2'(a);
      #1;
      check("R1");
    end

    // R2: each event position latched under the reset latch mask
    foreach (evt_pos[k]) begin
      if (evt_pos[k] == 6 || evt_pos[k] == 7) begin
        step(1'b1, 2'd1, 32'h000F80DF, 32'h0, "R9");
      end
      step(1'b0, 2'd0, 32'h0, 32'h1 << evt_pos[k], "R2");
      idle_read(2'd0, "R2");
      step(1'b1, 2'd0, 32'hFFFFFFFF, 32'h0, "R4");
      idle_read(2'd0, "R7");
    end

    // R3: narrow latch mask, events on every bit are dropped outside it
    step(1'b1, 2'd1, 32'h00000003, 32'h0, "R9");
    step(1'b0, 2'd0, 32'h0, 32'hFFFFFFFC, "R3");
    idle_read(2'd0, "R3");
    step(1'b0, 2'd0, 32'h0, 32'h00000003, "R2");
    idle_read(2'd0, "R2");

    // R10: dropping bits from the latch mask keeps recorded bits
    step(1'b1, 2'd1, 32'h0, 32'h0, "R10");
    idle_read(2'd0, "R10");
    step(1'b0, 2'd0, 32'h0, 32'hFFFFFFFF, "R10");
    idle_read(2'd0, "R10");

    // R4: partial clear leaves the other bit
    step(1'b1, 2'd0, 32'h00000001, 32'h0, "R4");
    idle_read(2'd0, "R4");

    // R5: event and clear on the same bit
    step(1'b1, 2'd1, 32'h000F80DF, 32'h0, "R9");
    step(1'b1, 2'd0, 32'h0000000F, 32'h00000005, "R5");
    idle_read(2'd0, "R5");

    // R6: summary bit follows error causes, not cleared directly
    step(1'b1, 2'd0, 32'hFFFFFFFF, 32'h0, "R4");
    step(1'b0, 2'd0, 32'h0, 32'h00048000, "R6");
    idle_read(2'd0, "R6");
    step(1'b1, 2'd0, 32'h00008000, 32'h0, "R6");
    idle_read(2'd0, "R6");
    step(1'b1, 2'd0, 32'h00040000, 32'h0, "R6");
    idle_read(2'd0, "R6");

    // R7: pin mask selects which bits reach the line
    step(1'b1, 2'd2, 32'h00000001, 32'h0, "R9");
    step(1'b0, 2'd0, 32'h0, 32'h00000002, "R7");
    idle_read(2'd0, "R7");
    step(1'b0, 2'd0, 32'h0, 32'h00000001, "R7");
    idle_read(2'd0, "R7");
    step(1'b1, 2'd0, 32'h00000001, 32'h0, "R7");
    idle_read(2'd0, "R7");
    step(1'b1, 2'd2, 32'h00008000, 32'h0, "R7");
    step(1'b0, 2'd0, 32'h0, 32'h00010000, "R7");
    idle_read(2'd0, "R7");
    idle_read(2'd0, "R7");

    // R8: both masks zero
    step(1'b1, 2'd0, 32'hFFFFFFFF, 32'h0, "R4");
    step(1'b1, 2'd1, 32'h0, 32'h0, "R8");
    step(1'b1, 2'd2, 32'h0, 32'h0, "R8");
    for (int i = 0; i < 8; i++) step(1'b0, 2'(i % 3), 32'h0, 32'hFFFFFFFF, "R8");

    // R9: unimplemented bits and unused address
    step(1'b1, 2'd1, 32'hFFFFFFFF, 32'h0, "R9");
    idle_read(2'd1, "R9");
    idle_read(2'd2, "R9");
    step(1'b1, 2'd2, 32'hFFFFFFFF, 32'h0, "R9");
    idle_read(2'd2, "R9");
    idle_read(2'd1, "R9");
    step(1'b1, 2'd3, 32'hFFFFFFFF, 32'h0, "R9");
    idle_read(2'd3, "R9");

    // mixed random traffic
    for (int i = 0; i < 1500; i++) begin
      logic [31:0] r = $urandom;
      logic        w = (r[3:0] < 4'd4);
      logic [31:0] d = (r[5:4] == 2'd0) ? $urandom : ($urandom & $urandom);
      logic [31:0] e = $urandom & $urandom & $urandom;
      step(w, r[9:8], d, e, "R2");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule